// File: doc/BRIEF.md
# Bus Unit Halt and Wake Controller

This block sequences the halt bus cycle of a simple 16-bit processor bus unit. When the execution unit asks to halt, the controller suspends the execution unit and steps the bus through one halt cycle of four T-states. It then parks the bus in a suspended state, where no new bus cycles start, until a wake event qualified by the current power mode arrives. During the halt cycle it drives a halt status code, keeps the upper address lines on the value of the last real bus cycle, and holds the chip-select logic inhibited. It floats or drives the multiplexed address/data bus in T1 depending on whether the last completed cycle was a write.

Wake sources are an interrupt request, a bus hold request, a DMA request and a refresh request. The interrupt always wakes the unit. The other three wake it only outside powerdown mode. A wake that arrives while T1 to T4 are still running is remembered and acted on once the cycle is complete. On waking, the block gives a one-clock resume strobe together with a code naming the winning source, and returns the bus to idle.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset, tstate is 0 (bus idle), bus_status is 3'b111 (passive), and ad_oe, cs_inhibit, eu_suspend and resume are all 0. upper_addr is 0.
- R2: halt_req sampled high while tstate is 0 moves tstate through 1, 2, 3 and 4 (T1 to T4) on consecutive clocks and then to 5 (suspended). eu_suspend is high whenever tstate is not 0.
- R3: bus_status is 3'b011 (halt code) while tstate is 1 and 3'b111 in every other state, so the halt code appears for exactly one clock per halt.
- R4: ad_oe is high in T1 only when the last bus cycle reported through cyc_end had cyc_wr high, and is low in every other state. The same preceding cycles always give the same ad_oe.
- R5: upper_addr shows the cyc_upper value of the last cycle reported through cyc_end, and does not change while tstate is not 0.
- R6: cs_inhibit is high exactly while tstate is 1 to 4.
- R7: With no qualified wake, tstate stays at 5. halt_req and cyc_end are ignored while tstate is not 0.
- R8: irq wakes the suspended unit in every power mode.
- R9: pwr_mode encodes 0 as active, 1 as idle, and 2 or 3 as powerdown. hold_req, dma_req and refresh_req wake the unit in modes 0 and 1. In powerdown they are neither acted on nor remembered.
- R10: A qualified wake seen at a clock edge while tstate is 5 makes tstate 0 and resume 1 for one clock after that edge. At the same time, wake_cause gives the winner: 0 interrupt, 1 hold, 2 DMA, 3 refresh. When several are present, the lowest code wins.
- R11: A qualified wake present during any clock of T1 to T4 is remembered. resume then rises on the clock after the first suspended clock, even if the source has gone away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Halt request from the execution unit |
| pwr_mode | input | 2 | Power mode: 0 active, 1 idle, 2/3 powerdown |
| irq | input | 1 | Interrupt wake request |
| hold_req | input | 1 | Bus hold wake request |
| dma_req | input | 1 | DMA wake request |
| refresh_req | input | 1 | Refresh wake request |
| cyc_end | input | 1 | A normal bus cycle completed this clock |
| cyc_wr | input | 1 | The completed cycle was a write |
| cyc_upper | input | UPPER_W | Upper address bits of the completed cycle |
| tstate | output | 3 | 0 idle, 1-4 T1-T4, 5 suspended |
| bus_status | output | 3 | Bus status code (3'b011 halt, 3'b111 passive) |
| ad_oe | output | 1 | Address/data bus output enable |
| upper_addr | output | UPPER_W | Upper address lines |
| cs_inhibit | output | 1 | Blocks programmed chip-selects |
| eu_suspend | output | 1 | Holds the execution unit suspended |
| resume | output | 1 | One-clock wake strobe |
| wake_cause | output | 2 | Source that caused the wake |

## Verification
The halt cycle is run after a read and after a write, so that the floated and driven T1 bus are told apart. The non-interrupt wake sources are held high in powerdown and shown to do nothing, while the same sources wake the unit in active and idle modes. Combinations of sources arriving together separate the priority order. Pulses that arrive during T2 or T1 check that a wake is remembered outside powerdown and dropped inside it. Bus cycles and halt requests given while suspended confirm that the stored bus history does not change and that a later halt repeats the earlier drive behaviour.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'd0,
        PM_IDLE     = 2'd1,
        PM_PDOWN    = 2'd2,
        PM_PDOWN_B  = 2'd3
    } pwr_mode_e;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_T4   = 3'd4,
        TS_SUSP = 3'd5
    } tstate_e;

    localparam logic [2:0] STAT_HALT    = 3'b011;
    localparam logic [2:0] STAT_PASSIVE = 3'b111;

    // wake source index: 0 interrupt, 1 hold, 2 dma, 3 refresh
    localparam int WAKE_N = 4;
    localparam int CAUSE_W = $clog2(WAKE_N);

    function automatic logic [CAUSE_W-1:0] wake_pick(input logic [WAKE_N-1:0] v);
        logic [CAUSE_W-1:0] r;
        r = '0;
        for (int i = WAKE_N - 1; i >= 0; i--) begin
            if (v[i]) r = CAUSE_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/hw_wake_qual.sv
module hw_wake_qual
    import halt_wake_pkg::*;
(
    input  logic [1:0]        pwr_mode,
    input  logic [WAKE_N-1:0] src,
    output logic [WAKE_N-1:0] qual
);
    logic mode_allows_bus;

    // powerdown is any mode with the upper bit set
    assign mode_allows_bus = (pwr_mode == PM_ACTIVE) || (pwr_mode == PM_IDLE);

    for (genvar i = 0; i < WAKE_N; i++) begin : g_src
        if (i == 0) begin : g_irq
            assign qual[i] = src[i];
        end else begin : g_bus
            assign qual[i] = src[i] & mode_allows_bus;
        end
    end
endmodule

// File: rtl/hw_bus_drive.sv
module hw_bus_drive #(
    parameter int UPPER_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_idle,
    input  logic               in_t1,
    input  logic               cyc_end,
    input  logic               cyc_wr,
    input  logic [UPPER_W-1:0] cyc_upper,
    output logic               ad_oe,
    output logic [UPPER_W-1:0] upper_addr
);
    typedef struct packed {
        logic               last_wr;
        logic [UPPER_W-1:0] last_upper;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (bus_idle && cyc_end) begin
            hist_d.last_wr    = cyc_wr;
            hist_d.last_upper = cyc_upper;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign ad_oe      = in_t1 & hist_q.last_wr;
    assign upper_addr = hist_q.last_upper;
endmodule

// File: rtl/hw_halt_seq.sv
module hw_halt_seq
    import halt_wake_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic [WAKE_N-1:0]  qual,
    output logic [2:0]         tstate,
    output logic [2:0]         bus_status,
    output logic               cs_inhibit,
    output logic               eu_suspend,
    output logic               bus_idle,
    output logic               in_t1,
    output logic               resume,
    output logic [CAUSE_W-1:0] wake_cause
);
    typedef struct packed {
        tstate_e            ts;
        logic [WAKE_N-1:0]  pend;
        logic               resume;
        logic [CAUSE_W-1:0] cause;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [WAKE_N-1:0] wake_any;

    assign wake_any = seq_q.pend | qual;

    always_comb begin
        seq_d        = seq_q;
        seq_d.resume = 1'b0;
        unique case (seq_q.ts)
            TS_IDLE: if (halt_req) seq_d.ts = TS_T1;
            TS_T1: begin
                seq_d.ts   = TS_T2;
                seq_d.pend = wake_any;
            end
            TS_T2: begin
                seq_d.ts   = TS_T3;
                seq_d.pend = wake_any;
            end
            TS_T3: begin
                seq_d.ts   = TS_T4;
                seq_d.pend = wake_any;
            end
            TS_T4: begin
                seq_d.ts   = TS_SUSP;
                seq_d.pend = wake_any;
            end
            TS_SUSP: begin
                if (|wake_any) begin
                    seq_d.ts     = TS_IDLE;
                    seq_d.resume = 1'b1;
                    seq_d.cause  = wake_pick(wake_any);
                    seq_d.pend   = '0;
                end
            end
            default: seq_d.ts = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ts     <= TS_IDLE;
            seq_q.pend   <= '0;
            seq_q.resume <= 1'b0;
            seq_q.cause  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tstate     = seq_q.ts;
    assign in_t1      = (seq_q.ts == TS_T1);
    assign bus_idle   = (seq_q.ts == TS_IDLE);
    assign bus_status = in_t1 ? STAT_HALT : STAT_PASSIVE;
    assign cs_inhibit = (seq_q.ts == TS_T1) || (seq_q.ts == TS_T2) ||
                        (seq_q.ts == TS_T3) || (seq_q.ts == TS_T4);
    assign eu_suspend = !bus_idle;
    assign resume     = seq_q.resume;
    assign wake_cause = seq_q.cause;
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import halt_wake_pkg::*;
#(
    parameter int UPPER_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic [1:0]         pwr_mode,
    input  logic               irq,
    input  logic               hold_req,
    input  logic               dma_req,
    input  logic               refresh_req,
    input  logic               cyc_end,
    input  logic               cyc_wr,
    input  logic [UPPER_W-1:0] cyc_upper,
    output logic [2:0]         tstate,
    output logic [2:0]         bus_status,
    output logic               ad_oe,
    output logic [UPPER_W-1:0] upper_addr,
    output logic               cs_inhibit,
    output logic               eu_suspend,
    output logic               resume,
    output logic [1:0]         wake_cause
);
    logic [WAKE_N-1:0] src_vec;
    logic [WAKE_N-1:0] qual_vec;
    logic              bus_idle;
    logic              in_t1;

    assign src_vec = {refresh_req, dma_req, hold_req, irq};

    hw_wake_qual u_qual (
        .pwr_mode (pwr_mode),
        .src      (src_vec),
        .qual     (qual_vec)
    );

    hw_halt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .qual       (qual_vec),
        .tstate     (tstate),
        .bus_status (bus_status),
        .cs_inhibit (cs_inhibit),
        .eu_suspend (eu_suspend),
        .bus_idle   (bus_idle),
        .in_t1      (in_t1),
        .resume     (resume),
        .wake_cause (wake_cause)
    );

    hw_bus_drive #(.UPPER_W(UPPER_W)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_idle   (bus_idle),
        .in_t1      (in_t1),
        .cyc_end    (cyc_end),
        .cyc_wr     (cyc_wr),
        .cyc_upper  (cyc_upper),
        .ad_oe      (ad_oe),
        .upper_addr (upper_addr)
    );
endmodule

// File: rtl/hw_halt_checker.sv
module hw_halt_checker #(
    parameter int UPPER_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         tstate,
    input logic [2:0]         bus_status,
    input logic               ad_oe,
    input logic [UPPER_W-1:0] upper_addr,
    input logic               cs_inhibit,
    input logic               resume,
    input logic               irq
);
    logic in_cycle;
    assign in_cycle = (tstate >= 3'd1) && (tstate <= 3'd4);

    p_seq_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tstate == 3'd1 |=> tstate == 3'd2);
    p_seq_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tstate == 3'd2 |=> tstate == 3'd3);
    p_seq_t3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tstate == 3'd3 |=> tstate == 3'd4);
    p_seq_t4_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tstate == 3'd4 |=> tstate == 3'd5);
    p_halt_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_status == 3'b011 |-> tstate == 3'd1);
    p_t1_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tstate == 3'd1 |-> bus_status == 3'b011);
    p_adoe_t1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> tstate == 3'd1);
    p_upper_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tstate != 3'd0 |=> $stable(upper_addr));
    p_inhibit_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_cycle |-> cs_inhibit);
    p_inhibit_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_inhibit |-> in_cycle);
    p_irq_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd5 && irq) |=> resume);
    p_resume_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> tstate == 3'd0);
    p_resume_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);
endmodule

bind halt_wake_ctrl hw_halt_checker #(.UPPER_W(UPPER_W)) u_halt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tstate     (tstate),
    .bus_status (bus_status),
    .ad_oe      (ad_oe),
    .upper_addr (upper_addr),
    .cs_inhibit (cs_inhibit),
    .resume     (resume),
    .irq        (irq)
);

// File: tb/halt_wake_ctrl_bench.sv
`timescale 1ns/1ps
module halt_wake_ctrl_bench;
    localparam int UW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_req = 1'b0;
    logic [1:0]    pwr_mode = 2'd0;
    logic          irq = 1'b0, hold_req = 1'b0, dma_req = 1'b0, refresh_req = 1'b0;
    logic          cyc_end = 1'b0, cyc_wr = 1'b0;
    logic [UW-1:0] cyc_upper = '0;
    logic [2:0]    tstate, bus_status;
    logic          ad_oe, cs_inhibit, eu_suspend, resume;
    logic [UW-1:0] upper_addr;
    logic [1:0]    wake_cause;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    halt_wake_ctrl #(.UPPER_W(UW)) u_halt_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .pwr_mode(pwr_mode),
        .irq(irq), .hold_req(hold_req), .dma_req(dma_req), .refresh_req(refresh_req),
        .cyc_end(cyc_end), .cyc_wr(cyc_wr), .cyc_upper(cyc_upper),
        .tstate(tstate), .bus_status(bus_status), .ad_oe(ad_oe),
        .upper_addr(upper_addr), .cs_inhibit(cs_inhibit), .eu_suspend(eu_suspend),
        .resume(resume), .wake_cause(wake_cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_wake(input logic [3:0] v);
        irq = v[0]; hold_req = v[1]; dma_req = v[2]; refresh_req = v[3];
    endtask

    task automatic bus_cycle(input logic wr, input logic [UW-1:0] up);
        cyc_end = 1'b1; cyc_wr = wr; cyc_upper = up;
        tick();
        cyc_end = 1'b0;
    endtask

    // requests a halt and checks T1..T4 plus arrival at the suspended state
    task automatic run_halt(input logic exp_ad, input logic [UW-1:0] exp_up);
        halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
        chk("R2 T1 state", tstate, 1);
        chk("R3 T1 halt code", bus_status, 3'b011);
        chk("R4 T1 ad_oe", ad_oe, exp_ad);
        chk("R6 T1 inhibit", cs_inhibit, 1);
        chk("R5 T1 upper", upper_addr, exp_up);
        chk("R2 T1 suspend", eu_suspend, 1);
        for (int k = 2; k <= 4; k++) begin
            tick();
            chk("R2 T2-T4 state", tstate, k);
            chk("R3 T2-T4 passive", bus_status, 3'b111);
            chk("R4 T2-T4 ad_oe low", ad_oe, 0);
            chk("R6 T2-T4 inhibit", cs_inhibit, 1);
            chk("R5 T2-T4 upper", upper_addr, exp_up);
        end
        tick();
        chk("R2 suspended state", tstate, 5);
        chk("R6 inhibit released", cs_inhibit, 0);
        chk("R2 suspend held", eu_suspend, 1);
    endtask

    task automatic wake_and_check(input logic [3:0] v, input logic [1:0] exp_cause, input string tag);
        set_wake(v);
        tick();
        set_wake(4'b0);
        chk({tag, " resume"}, resume, 1);
        chk({tag, " idle"}, tstate, 0);
        chk({tag, " cause"}, wake_cause, exp_cause);
        chk({tag, " suspend low"}, eu_suspend, 0);
        tick();
        chk("R10 resume one clock", resume, 0);
    endtask

    task automatic t_reset();
        chk("R1 tstate", tstate, 0);
        chk("R1 status", bus_status, 3'b111);
        chk("R1 ad_oe", ad_oe, 0);
        chk("R1 inhibit", cs_inhibit, 0);
        chk("R1 suspend", eu_suspend, 0);
        chk("R1 resume", resume, 0);
        chk("R1 upper", upper_addr, 0);
    endtask

    task automatic t_after_read_irq();
        pwr_mode = 2'd0;
        bus_cycle(1'b0, 4'hA);
        run_halt(1'b0, 4'hA);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7 stays suspended", tstate, 5);
            chk("R7 no resume", resume, 0);
        end
        wake_and_check(4'b0001, 2'd0, "R8 irq active");
    endtask

    task automatic t_powerdown();
        pwr_mode = 2'd2;
        bus_cycle(1'b1, 4'h5);
        run_halt(1'b1, 4'h5);
        set_wake(4'b1110);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R9 pdown ignores bus wakes", tstate, 5);
            chk("R9 pdown no resume", resume, 0);
        end
        pwr_mode = 2'd3;
        tick();
        chk("R9 mode 3 ignores bus wakes", tstate, 5);
        wake_and_check(4'b1111, 2'd0, "R8 irq powerdown");
    endtask

    task automatic t_priority();
        pwr_mode = 2'd1;
        run_halt(1'b1, 4'h5);
        wake_and_check(4'b1010, 2'd1, "R10 hold over refresh");
        run_halt(1'b1, 4'h5);
        wake_and_check(4'b1100, 2'd2, "R10 dma over refresh");
        run_halt(1'b1, 4'h5);
        wake_and_check(4'b1000, 2'd3, "R10 refresh alone");
        run_halt(1'b1, 4'h5);
        wake_and_check(4'b0111, 2'd0, "R10 irq first");
    endtask

    task automatic t_latch();
        pwr_mode = 2'd0;
        halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
        tick();
        refresh_req = 1'b1;
        tick();
        refresh_req = 1'b0;
        tick();
        tick();
        chk("R11 first suspended clock", tstate, 5);
        chk("R11 not yet resumed", resume, 0);
        tick();
        chk("R11 latched resume", resume, 1);
        chk("R11 latched cause", wake_cause, 3);
        tick();
        pwr_mode = 2'd2;
        halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
        hold_req = 1'b1;
        tick();
        hold_req = 1'b0;
        for (int k = 0; k < 5; k++) tick();
        chk("R9 pdown wake not latched", tstate, 5);
        chk("R9 pdown latch no resume", resume, 0);
        wake_and_check(4'b0001, 2'd0, "R8 irq after pdown latch");
    endtask

    task automatic t_ignore();
        pwr_mode = 2'd0;
        run_halt(1'b1, 4'h5);
        halt_req = 1'b1;
        cyc_end = 1'b1; cyc_wr = 1'b0; cyc_upper = 4'hF;
        tick();
        halt_req = 1'b0;
        cyc_end = 1'b0;
        chk("R7 halt_req ignored", tstate, 5);
        chk("R7 cyc_end ignored upper", upper_addr, 4'h5);
        wake_and_check(4'b0001, 2'd0, "R10 wake after ignore");
        run_halt(1'b1, 4'h5);
        wake_and_check(4'b0001, 2'd0, "R10 wake repeat");
        bus_cycle(1'b0, 4'h3);
        chk("R5 upper after new cycle", upper_addr, 4'h3);
        run_halt(1'b0, 4'h3);
        wake_and_check(4'b0100, 2'd2, "R10 dma active");
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        tick();
        t_reset();
        t_after_read_irq();
        t_powerdown();
        t_priority();
        t_latch();
        t_ignore();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule